// File: doc/BRIEF.md
# Staged Serial Configuration Commit

This block holds the configuration of an asynchronous serial transmitter in two layers. A host writes mode, modem-control port, character format and baud divisor values through a small register port. The writes land in a shadow layer only, and a pending flag is raised. The live layer, which drives the transmitter, takes the staged values only while the transmitter reports that it is idle. A reconfiguration can therefore never change a character that is already being shifted out.

Being idle is treated as a level, not as an event. If the transmitter is already idle when a value is staged, the commit follows on the next clock without waiting for a new idle transition. All staged fields are copied in one clock edge, so the transmitter never sees a mix of old and new settings. The upper divisor bits share a clock-control register with six bits that the host writes directly. A commit replaces only the divisor bits of that register and keeps the other six.

The register port has no back-pressure. A write strobe is accepted on every clock in which it is high, and read data is a combinational function of the read address. Control inputs and status outputs are plain level signals.

Top module: `cfg_deferred_commit`

## Requirements
- R1: After reset the pending flag is 0, the shadow and live fields hold the same defaults (mode 0x00, port 0x16, format 0x03, divisor low 0x0B, divisor high 0), and the direct clock-control bits are 0.
- R2: A write to address 0 (mode), 1 (port), 2 (format), 3 (divisor low) or 4 (divisor high, bits 1:0) changes only the shadow copy and sets the pending flag at the same edge. While tx_idle is low, no live field changes.
- R3: At a clock edge where the pending flag and tx_idle are both high, all five live fields take the shadow values together and the pending flag clears, unless a staged write arrives at that edge.
- R4: If tx_idle is already high when a value is staged, the live field shows the new value one edge after the write edge.
- R5: A staged write that arrives at the commit edge is not part of that commit. It stays in the shadow copy and keeps the pending flag set for the next idle point.
- R6: live_clkctl bits 7:6 hold the live divisor high bits. A commit does not change live_clkctl bits 5:0.
- R7: A write to address 5 sets live_clkctl bits 5:0 from wr_data bits 5:0 at the next edge, regardless of tx_idle. It does not change the pending flag, and wr_data bits 7:6 are ignored.
- R8: The format byte is decoded from the live copy: bits 1:0 give the character length (5 + code), bit 2 selects two stop bits, bit 3 enables parity and bit 4 selects odd parity.
- R9: Format bit 5 forces a transmit break. Setting or clearing it is staged and reaches tx_break only through a commit.
- R10: Writes to addresses 6 and 7 change no shadow field, no live field and no pending flag.
- R11: rd_data returns the shadow value for addresses 0 to 4 (divisor high zero-extended), live_clkctl for address 5, and 0 for addresses 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tx_idle | input | 1 | Transmitter idle level |
| cfg_pending | output | 1 | Staged values not yet committed |
| live_mode | output | 8 | Live mode byte |
| live_port | output | 8 | Live modem-control port byte |
| live_fmt | output | 8 | Live format byte |
| live_div_lo | output | 8 | Live divisor bits 7:0 |
| live_clkctl | output | 8 | Live clock-control: divisor bits 9:8 in 7:6, direct bits in 5:0 |
| char_bits | output | 4 | Decoded character length, 5 to 8 |
| two_stop | output | 1 | Two stop bits selected |
| parity_en | output | 1 | Parity enabled |
| parity_odd | output | 1 | Odd parity selected |
| tx_break | output | 1 | Transmit break forced |

## Verification
The assertions assume that wr_addr, wr_data and tx_idle are settled at every clock edge, and that tx_idle may toggle on any cycle, with no minimum idle time. The stimulus changes inputs only between edges. It mixes long busy stretches with idle levels that are already high when a write arrives, writes that land exactly on a commit edge, and writes to the direct clock-control and unused addresses. The checks therefore reach the corner cases above and do not rely on well-spaced host activity.

// File: rtl/cfg_stage_pkg.sv
package cfg_stage_pkg;
  localparam int unsigned NFIELD = 5;

  typedef enum logic [2:0] {
    ADR_MODE  = 3'd0,
    ADR_PORT  = 3'd1,
    ADR_FMT   = 3'd2,
    ADR_DIVLO = 3'd3,
    ADR_DIVHI = 3'd4,
    ADR_CLK   = 3'd5
  } cfg_addr_e;

  // format byte bit positions
  localparam int unsigned FMT_LEN_LSB = 0;
  localparam int unsigned FMT_STOP2   = 2;
  localparam int unsigned FMT_PAREN   = 3;
  localparam int unsigned FMT_PARODD  = 4;
  localparam int unsigned FMT_BRK     = 5;
endpackage

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank #(
  parameter int unsigned DW = 8,
  parameter int unsigned NF = 5,
  parameter int unsigned AW = 3,
  parameter logic [NF*DW-1:0] RST_VALS = '0,
  parameter logic [NF*DW-1:0] FIELD_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [NF*DW-1:0] shadow_flat,
  output logic             staged_wr
);
  assign staged_wr = wr_en && (32'(wr_addr) < NF);

  for (genvar i = 0; i < NF; i++) begin : g_fld
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= RST_VALS[i*DW +: DW];
      else if (wr_en && (32'(wr_addr) == i))
        q <= wr_data & FIELD_MASK[i*DW +: DW];
    end
    assign shadow_flat[i*DW +: DW] = q;
  end
endmodule

// File: rtl/cfg_commit_ctrl.sv
module cfg_commit_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic staged_wr,
  input  logic tx_idle,
  output logic pending,
  output logic commit
);
  logic pending_q;

  assign commit  = pending_q && tx_idle;
  assign pending = pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pending_q <= 1'b0;
    else if (staged_wr)
      pending_q <= 1'b1;
    else if (commit)
      pending_q <= 1'b0;
  end
endmodule

// File: rtl/cfg_live_bank.sv
module cfg_live_bank #(
  parameter int unsigned DW = 8,
  parameter int unsigned NF = 5,
  parameter int unsigned HI_W = 2,
  parameter logic [NF*DW-1:0] RST_VALS = '0,
  parameter logic [DW-HI_W-1:0] CLK_LO_RST = '0,
  localparam int unsigned LO_W = DW - HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [NF*DW-1:0] shadow_flat,
  input  logic             clk_lo_wr,
  input  logic [LO_W-1:0]  clk_lo_data,
  output logic [NF*DW-1:0] live_flat,
  output logic [DW-1:0]    clkctl
);
  logic [LO_W-1:0] clk_lo_q;

  for (genvar i = 0; i < NF; i++) begin : g_live
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= RST_VALS[i*DW +: DW];
      else if (commit)
        q <= shadow_flat[i*DW +: DW];
    end
    assign live_flat[i*DW +: DW] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      clk_lo_q <= CLK_LO_RST;
    else if (clk_lo_wr)
      clk_lo_q <= clk_lo_data;
  end

  // the last field carries the divisor high bits
  assign clkctl = {live_flat[(NF-1)*DW +: HI_W], clk_lo_q};
endmodule

// File: rtl/cfg_deferred_commit.sv
module cfg_deferred_commit
  import cfg_stage_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3,
  parameter int unsigned DIV_W = 10,
  parameter logic [DW-1:0] MODE_RST = 8'h00,
  parameter logic [DW-1:0] PORT_RST = 8'h16,
  parameter logic [DW-1:0] FMT_RST  = 8'h03,
  parameter logic [DIV_W-1:0] DIV_RST = 10'h00B,
  parameter logic [2*DW-DIV_W-1:0] CLK_LO_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          tx_idle,
  output logic          cfg_pending,
  output logic [DW-1:0] live_mode,
  output logic [DW-1:0] live_port,
  output logic [DW-1:0] live_fmt,
  output logic [DW-1:0] live_div_lo,
  output logic [DW-1:0] live_clkctl,
  output logic [3:0]    char_bits,
  output logic          two_stop,
  output logic          parity_en,
  output logic          parity_odd,
  output logic          tx_break
);
  localparam int unsigned HI_W = DIV_W - DW;
  localparam int unsigned LO_W = DW - HI_W;
  localparam logic [DW-1:0] HI_MASK = {{LO_W{1'b0}}, {HI_W{1'b1}}};
  localparam logic [DW-1:0] HI_RST  = {{LO_W{1'b0}}, DIV_RST[DIV_W-1:DW]};
  localparam logic [NFIELD*DW-1:0] RST_VALS =
    {HI_RST, DIV_RST[DW-1:0], FMT_RST, PORT_RST, MODE_RST};
  localparam logic [NFIELD*DW-1:0] FIELD_MASK =
    {HI_MASK, {(NFIELD-1)*DW{1'b1}}};

  logic [NFIELD*DW-1:0] shadow_flat;
  logic [NFIELD*DW-1:0] live_flat;
  logic                 staged_wr;
  logic                 commit;
  logic                 clk_lo_wr;

  assign clk_lo_wr = wr_en && (wr_addr == AW'(ADR_CLK));

  cfg_shadow_bank #(
    .DW(DW), .NF(NFIELD), .AW(AW), .RST_VALS(RST_VALS), .FIELD_MASK(FIELD_MASK)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .shadow_flat(shadow_flat), .staged_wr(staged_wr)
  );

  cfg_commit_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .staged_wr(staged_wr), .tx_idle(tx_idle),
    .pending(cfg_pending), .commit(commit)
  );

  cfg_live_bank #(
    .DW(DW), .NF(NFIELD), .HI_W(HI_W), .RST_VALS(RST_VALS), .CLK_LO_RST(CLK_LO_RST)
  ) u_live (
    .clk(clk), .rst_n(rst_n), .commit(commit), .shadow_flat(shadow_flat),
    .clk_lo_wr(clk_lo_wr), .clk_lo_data(wr_data[LO_W-1:0]),
    .live_flat(live_flat), .clkctl(live_clkctl)
  );

  assign live_mode   = live_flat[ADR_MODE*DW  +: DW];
  assign live_port   = live_flat[ADR_PORT*DW  +: DW];
  assign live_fmt    = live_flat[ADR_FMT*DW   +: DW];
  assign live_div_lo = live_flat[ADR_DIVLO*DW +: DW];

  assign char_bits  = 4'd5 + {2'b00, live_fmt[FMT_LEN_LSB +: 2]};
  assign two_stop   = live_fmt[FMT_STOP2];
  assign parity_en  = live_fmt[FMT_PAREN];
  assign parity_odd = live_fmt[FMT_PARODD];
  assign tx_break   = live_fmt[FMT_BRK];

  always_comb begin
    rd_data = '0;
    if (32'(rd_addr) < NFIELD)
      rd_data = shadow_flat[32'(rd_addr)*DW +: DW];
    else if (rd_addr == AW'(ADR_CLK))
      rd_data = live_clkctl;
  end
endmodule

// File: rtl/cfg_deferred_commit_chk.sv
module cfg_deferred_commit_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3,
  parameter int unsigned NF = 5,
  parameter int unsigned HI_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic             tx_idle,
  input logic             cfg_pending,
  input logic [DW-1:0]    live_mode,
  input logic [DW-1:0]    live_port,
  input logic [DW-1:0]    live_fmt,
  input logic [DW-1:0]    live_div_lo,
  input logic [DW-1:0]    live_clkctl,
  input logic [3:0]       char_bits,
  input logic [NF*DW-1:0] shadow_flat
);
  localparam int unsigned LO_W = DW - HI_W;
  logic stage_in;
  assign stage_in = wr_en && (32'(wr_addr) < NF);

  // R2
  stage_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_in |=> cfg_pending);

  // R2
  busy_holds_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_pending && tx_idle) |=> ($stable(live_mode) && $stable(live_port) &&
      $stable(live_fmt) && $stable(live_div_lo) && $stable(live_clkctl[DW-1:LO_W])));

  // R3
  commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pending && tx_idle && !stage_in) |=> !cfg_pending);

  // R3
  commit_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pending && tx_idle) |=>
      ({live_div_lo, live_fmt, live_port, live_mode} == $past(shadow_flat[4*DW-1:0])));

  // R6
  commit_div_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pending && tx_idle) |=>
      (live_clkctl[DW-1:LO_W] == $past(shadow_flat[(NF-1)*DW +: HI_W])));

  // R7
  clk_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == AW'(5)) |=> $stable(live_clkctl[LO_W-1:0]));

  // R8
  char_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_bits >= 4'd5) && (char_bits <= 4'd8));
endmodule

bind cfg_deferred_commit cfg_deferred_commit_chk #(
  .DW(DW), .AW(AW), .NF(cfg_stage_pkg::NFIELD), .HI_W(DIV_W - DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .tx_idle(tx_idle),
  .cfg_pending(cfg_pending), .live_mode(live_mode), .live_port(live_port),
  .live_fmt(live_fmt), .live_div_lo(live_div_lo), .live_clkctl(live_clkctl),
  .char_bits(char_bits), .shadow_flat(shadow_flat)
);

// File: tb/cfg_deferred_commit_tb.sv
`timescale 1ns/1ps
module cfg_deferred_commit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tx_idle = 1'b0;
  logic       cfg_pending;
  logic [7:0] live_mode, live_port, live_fmt, live_div_lo, live_clkctl;
  logic [3:0] char_bits;
  logic       two_stop, parity_en, parity_odd, tx_break;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // reference state
  int sh[5];
  int lv[5];
  int clklo;
  bit pend;

  always #4 clk = ~clk;

  cfg_deferred_commit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_idle(tx_idle), .cfg_pending(cfg_pending),
    .live_mode(live_mode), .live_port(live_port), .live_fmt(live_fmt),
    .live_div_lo(live_div_lo), .live_clkctl(live_clkctl), .char_bits(char_bits),
    .two_stop(two_stop), .parity_en(parity_en), .parity_odd(parity_odd),
    .tx_break(tx_break)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_rd(int a);
    if (a < 5) return sh[a];
    if (a == 5) return ((lv[4] & 3) << 6) | clklo;
    return 0;
  endfunction

  task automatic compare_all();
    chk(cur_req, "pending", cfg_pending, pend);
    chk(cur_req, "live_mode", live_mode, lv[0]);
    chk(cur_req, "live_port", live_port, lv[1]);
    chk(cur_req, "live_fmt", live_fmt, lv[2]);
    chk(cur_req, "live_div_lo", live_div_lo, lv[3]);
    chk(cur_req, "live_clkctl", live_clkctl, ((lv[4] & 3) << 6) | clklo);
    chk(cur_req, "char_bits", char_bits, 5 + (lv[2] & 3));
    chk(cur_req, "two_stop", two_stop, (lv[2] >> 2) & 1);
    chk(cur_req, "parity_en", parity_en, (lv[2] >> 3) & 1);
    chk(cur_req, "parity_odd", parity_odd, (lv[2] >> 4) & 1);
    chk(cur_req, "tx_break", tx_break, (lv[2] >> 5) & 1);
    chk(cur_req, "rd_data", rd_data, exp_rd(rd_addr));
  endtask

  task automatic step(bit we, int a, int d, bit idle, int ra);
    bit staged, commit;
    wr_en = we; wr_addr = 3'(a); wr_data = 8'(d); tx_idle = idle; rd_addr = 3'(ra);
    @(posedge clk);
    commit = pend && idle;
    staged = we && (a < 5);
    if (commit) for (int i = 0; i < 5; i++) lv[i] = sh[i];
    if (staged) sh[a] = (a == 4) ? (d & 3) : (d & 255);
    if (we && a == 5) clklo = d & 63;
    pend = staged || (pend && !idle);
    #2;
    compare_all();
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sh = '{8'h00, 8'h16, 8'h03, 8'h0B, 0};
    lv = sh;
    clklo = 0;
    pend = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1: defaults after reset
    cur_req = "R1";
    for (int a = 0; a < 8; a++) begin rd_addr = 3'(a); #1 compare_all(); end

    // R2: staged while busy, live held
    cur_req = "R2";
    step(1, 0, 8'hA5, 0, 0);
    step(1, 3, 8'h40, 0, 3);
    repeat (4) step(0, 0, 0, 0, 0);
    // R3: commit when idle
    cur_req = "R3";
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 1, 1);
    // R4: idle already high when value staged
    cur_req = "R4";
    step(1, 1, 8'h3C, 1, 1);
    step(0, 0, 0, 1, 1);
    // R5: write at the commit edge re-arms
    cur_req = "R5";
    step(1, 0, 8'h11, 0, 0);
    step(1, 0, 8'h22, 1, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    // R6: divisor high goes to clkctl 7:6
    cur_req = "R6";
    step(1, 5, 8'h2A, 0, 5);
    step(1, 4, 8'hFF, 0, 4);
    step(0, 0, 0, 1, 5);
    // R7: direct clkctl bits, no staging
    cur_req = "R7";
    step(1, 5, 8'hD5, 0, 5);
    step(0, 0, 0, 0, 5);
    // R8: format decode
    cur_req = "R8";
    step(1, 2, 8'h1C, 1, 2);
    step(0, 0, 0, 1, 2);
    step(1, 2, 8'h09, 1, 2);
    step(0, 0, 0, 1, 2);
    // R9: break is staged
    cur_req = "R9";
    step(1, 2, 8'h23, 0, 2);
    step(0, 0, 0, 0, 2);
    step(0, 0, 0, 1, 2);
    step(1, 2, 8'h03, 0, 2);
    step(0, 0, 0, 1, 2);
    // R10: unused addresses
    cur_req = "R10";
    step(1, 6, 8'hFF, 0, 6);
    step(1, 7, 8'hFF, 1, 7);
    // R11: read back of every address
    cur_req = "R11";
    for (int a = 0; a < 8; a++) step(0, 0, 0, 0, a);

    // mixed traffic
    cur_req = "R3";
    for (int n = 0; n < 3000; n++) begin
      int ph = (n / 200) % 3;
      bit idle = (ph == 0) ? ($urandom % 8 == 0) : (ph == 1) ? 1'b1 : ($urandom % 2 == 0);
      step(($urandom % 3) == 0, $urandom % 8, $urandom % 256, idle, $urandom % 8);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule